// File: doc/BRIEF.md
# Branch Clock Gate Controller

This block gates one peripheral branch clock under register control. A small register port in the bus clock domain holds three registers: a control register with a software enable bit and a read-only "clock off" flag, a vote register with one bit per voting master, and a block-reset register that drives a reset line into the downstream logic. The branch clock runs when either the local enable bit or this branch's own vote bit is set. Any other master's vote bit has no effect on this branch.

The effective request crosses into the source clock domain through a two-flop synchronizer. It then drives a gate whose enable changes only while the source clock is low, so every output pulse is a full source-clock high phase. The gate's real state comes back into the bus domain through a second two-flop synchronizer and drives the off flag. Software therefore sees the actual clock state, which trails the request by a few cycles. Software enables the clock, polls the off flag until it clears, and treats a long wait as a failure.

Top module: `branch_clk_gate`

## Requirements
- R1: Writing address 0 stores data bit 0 as the local enable; reading address 0 returns that bit in bit 0, and bits 30:1 read 0.
- R2: Bit 31 of address 0 is read-only. It reads 1 while the branch clock is gated off and 0 while it runs, and writing it has no effect on the flag or on the clock.
- R3: Address 1 holds VOTERS vote bits (default 4) that read back as written. Vote bit VOTE_IDX (default 2) runs the clock even when the local enable is 0; the other vote bits do not affect this branch.
- R4: Bit 0 of address 2 drives `blkRstOut` high while it is 1 and low once it is cleared; the other bits of that register are ignored and read 0.
- R5: `gatedClk` carries source-clock pulses only while the effective enable (local enable OR selected vote bit) is set. Each pulse is exactly one full source high phase, and no partial pulse is ever produced.
- R6: The off flag follows the gate's real state, not the request. It is still 1 in the first bus cycle after an enabling write, it clears within 12 bus cycles, and it sets again within 12 bus cycles after the request drops.
- R7: After reset the enable, vote and block-reset registers are 0, the off flag reads 1, `gatedClk` stays low and `blkRstOut` is 0.
- R8: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Register port clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| srcClk | input | 1 | Source clock to be gated |
| srcRstN | input | 1 | Active-low asynchronous reset, source domain |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| gatedClk | output | 1 | Gated branch clock |
| blkRstOut | output | 1 | Downstream block reset, active high |

## Verification
The hardest part to reach from the ports is the gap between the request and the reported state. That gap only shows up when the bus and source clocks run at unrelated periods, so the bench uses 8 ns and 10 ns. It samples the off flag in the first bus cycle after each enabling write, then polls until the flag settles. Every value of the vote register is swept, with the local enable both off and on. For each value the bench counts gated pulses over a fixed 200 ns window and times the width of every pulse, so that a gate changing while the source clock is high would show up as a short pulse.

// File: rtl/branch_gate_pkg.sv
package branch_gate_pkg;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_VOTE = 2'd1,
    SEL_RST  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  typedef struct packed {
    logic wrCtl;
    logic wrVote;
    logic wrRst;
  } branchStrobes_t;

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_gate_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output branchStrobes_t    strobes,
  output regSel_t           rdSel
);

  always_comb begin
    rdSel = SEL_NONE;
    case (addr)
      ADDR_W'(0): rdSel = SEL_CTL;
      ADDR_W'(1): rdSel = SEL_VOTE;
      ADDR_W'(2): rdSel = SEL_RST;
      default:    rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.wrCtl  = wrEn && (rdSel == SEL_CTL);
    strobes.wrVote = wrEn && (rdSel == SEL_VOTE);
    strobes.wrRst  = wrEn && (rdSel == SEL_RST);
  end

endmodule

// File: rtl/branch_regs.sv
module branch_regs
  import branch_gate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int VOTERS   = 4,
  parameter int VOTE_IDX = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  branchStrobes_t    strobes,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              gateOnAsync,
  output logic              reqEn,
  output logic              blkRstOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int OFF_BIT = DATA_W - 1;

  logic              ctlEn;
  logic [VOTERS-1:0] voteReg;
  logic              rstBit;
  logic              onMeta;
  logic              onSync;
  logic              offFlag;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:VOTERS];

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      ctlEn   <= 1'b0;
      voteReg <= '0;
      rstBit  <= 1'b0;
    end else begin
      if (strobes.wrCtl)  ctlEn   <= wrData[0];
      if (strobes.wrVote) voteReg <= wrData[VOTERS-1:0];
      if (strobes.wrRst)  rstBit  <= wrData[0];
    end
  end

  // Gate state back into the bus domain: two-flop synchronizer.
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      onMeta <= 1'b0;
      onSync <= 1'b0;
    end else begin
      onMeta <= gateOnAsync;
      onSync <= onMeta;
    end
  end

  assign offFlag   = ~onSync;
  assign reqEn     = ctlEn | voteReg[VOTE_IDX];
  assign blkRstOut = rstBit;

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_CTL: begin
        rdData[0]       = ctlEn;
        rdData[OFF_BIT] = offFlag;
      end
      SEL_VOTE: rdData[VOTERS-1:0] = voteReg;
      SEL_RST:  rdData[0] = rstBit;
      default:  rdData = '0;
    endcase
  end

  p_ctl_write_r1: assert property (@(posedge busClk) disable iff (!busRstN)
    strobes.wrCtl |=> (ctlEn == $past(wrData[0])));
  p_ctl_hold_r1: assert property (@(posedge busClk) disable iff (!busRstN)
    !strobes.wrCtl |=> $stable(ctlEn));
  p_vote_write_r3: assert property (@(posedge busClk) disable iff (!busRstN)
    strobes.wrVote |=> (voteReg == $past(wrData[VOTERS-1:0])));
  p_vote_hold_r3: assert property (@(posedge busClk) disable iff (!busRstN)
    !strobes.wrVote |=> $stable(voteReg));
  p_rst_write_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    strobes.wrRst |=> (blkRstOut == $past(wrData[0])));
  p_rst_hold_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    !strobes.wrRst |=> $stable(blkRstOut));

endmodule

// File: rtl/branch_gate.sv
module branch_gate (
  input  logic srcClk,
  input  logic srcRstN,
  input  logic reqEn,
  output logic gateOn,
  output logic gatedClk
);

  logic reqMeta;
  logic reqSync;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      reqMeta <= 1'b0;
      reqSync <= 1'b0;
    end else begin
      reqMeta <= reqEn;
      reqSync <= reqMeta;
    end
  end

  // Enable moves only on the falling edge, while the source clock is low.
  always_ff @(negedge srcClk or negedge srcRstN) begin
    if (!srcRstN) gateOn <= 1'b0;
    else          gateOn <= reqSync;
  end

  assign gatedClk = srcClk & gateOn;

  p_gate_reset_r7: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $past(!srcRstN) |-> !gateOn);

endmodule

// File: rtl/branch_clk_gate.sv
module branch_clk_gate
  import branch_gate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int VOTERS   = 4,
  parameter int VOTE_IDX = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              gatedClk,
  output logic              blkRstOut
);

  branchStrobes_t strobes;
  regSel_t        rdSel;
  logic           reqEn;
  logic           gateOn;

  branch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  branch_regs #(
    .DATA_W   (DATA_W),
    .VOTERS   (VOTERS),
    .VOTE_IDX (VOTE_IDX)
  ) u_regs (
    .busClk      (busClk),
    .busRstN     (busRstN),
    .strobes     (strobes),
    .rdSel       (rdSel),
    .wrData      (wrData),
    .gateOnAsync (gateOn),
    .reqEn       (reqEn),
    .blkRstOut   (blkRstOut),
    .rdData      (rdData)
  );

  branch_gate u_gate (
    .srcClk   (srcClk),
    .srcRstN  (srcRstN),
    .reqEn    (reqEn),
    .gateOn   (gateOn),
    .gatedClk (gatedClk)
  );

endmodule

// File: tb/branch_clk_gate_bench.sv
`timescale 1ns/1ps
module branch_clk_gate_bench;

  logic        busClk = 1'b0;
  logic        srcClk = 1'b0;
  logic        busRstN = 1'b0;
  logic        srcRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        gatedClk;
  logic        blkRstOut;

  int tests = 0;
  int fails = 0;
  int pulseCount = 0;
  int shortPulses = 0;
  realtime riseTime = 0.0;

  always #4 busClk = ~busClk;   // 125 MHz
  always #5 srcClk = ~srcClk;   // 100 MHz, unrelated phase

  branch_clk_gate u_branch_clk_gate (
    .busClk (busClk), .busRstN (busRstN), .srcClk (srcClk), .srcRstN (srcRstN),
    .wrEn (wrEn), .addr (addr), .wrData (wrData), .rdData (rdData),
    .gatedClk (gatedClk), .blkRstOut (blkRstOut)
  );

  always @(posedge gatedClk) begin
    pulseCount++;
    riseTime = $realtime;
  end
  always @(negedge gatedClk) begin
    if ($realtime - riseTime != 5.0) shortPulses++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge busClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge busClk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic countPulses(output int n);
    @(negedge busClk);
    pulseCount = 0;
    #200;
    n = pulseCount;
  endtask

  task automatic settle();
    repeat (14) @(negedge busClk);
  endtask

  // Poll off flag until it equals want; returns bus cycles taken (99 if never).
  task automatic pollOff(input logic want, output int cyc);
    logic [31:0] v;
    cyc = 99;
    for (int i = 1; i <= 12; i++) begin
      regRead(2'd0, v);
      if (v[31] == want) begin cyc = i; break; end
    end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, cyc;
    repeat (3) @(negedge busClk);
    busRstN = 1'b1; srcRstN = 1'b1;
    repeat (2) @(negedge busClk);

    // R7 reset state
    regRead(2'd0, v); check("R7 ctl after reset", v, 32'h8000_0000);
    regRead(2'd1, v); check("R7 vote after reset", v, 32'h0);
    regRead(2'd2, v); check("R7 blkrst reg after reset", v, 32'h0);
    check("R7 blkRstOut after reset", {31'b0, blkRstOut}, 32'h0);
    countPulses(n); check("R7 no pulses after reset", n, 0);

    // R1/R6 enable with lag
    regWrite(2'd0, 32'h1);
    check("R6 off flag lags request", {31'b0, rdData[31]}, 32'h1);
    pollOff(1'b0, cyc);
    check("R6 off clears within 12 cycles", {31'b0, cyc <= 12}, 32'h1);
    regRead(2'd0, v); check("R1 ctl readback running", v, 32'h1);
    countPulses(n); check("R5 pulses while enabled", n, 20);

    // R2 bit31 write ignored while running
    regWrite(2'd0, 32'h8000_0001); settle();
    regRead(2'd0, v); check("R2 bit31 write ignored running", v, 32'h1);

    // R6 disable
    regWrite(2'd0, 32'h0);
    pollOff(1'b1, cyc);
    check("R6 off sets within 12 cycles", {31'b0, cyc <= 12}, 32'h1);
    countPulses(n); check("R5 no pulses when disabled", n, 0);

    // R2 bit31 alone does not enable
    regWrite(2'd0, 32'h8000_0000); settle();
    regRead(2'd0, v); check("R2 bit31 write ignored stopped", v, 32'h8000_0000);
    countPulses(n); check("R2 clock stays off", n, 0);

    // R3 vote sweep with local enable off then on
    for (int en = 0; en < 2; en++) begin
      regWrite(2'd0, en);
      for (int vv = 0; vv < 16; vv++) begin
        bit runs;
        runs = (en == 1) || vv[2];
        regWrite(2'd1, 32'hFFFF_FFF0 | vv);
        settle();
        regRead(2'd1, v); check("R3 vote readback", v, vv);
        regRead(2'd0, v); check("R3 off flag vs vote", v, {~runs, 30'b0, en[0]});
        countPulses(n); check("R3 pulses vs vote", n, runs ? 20 : 0);
      end
    end
    regWrite(2'd1, 32'h0);
    regWrite(2'd0, 32'h0);
    settle();

    // R4 block reset
    regWrite(2'd2, 32'h1);
    check("R4 blkRstOut asserted", {31'b0, blkRstOut}, 32'h1);
    regRead(2'd2, v); check("R4 reg readback set", v, 32'h1);
    regWrite(2'd2, 32'hFFFF_FFFE);
    check("R4 blkRstOut released", {31'b0, blkRstOut}, 32'h0);
    regRead(2'd2, v); check("R4 upper bits ignored", v, 32'h0);
    regWrite(2'd2, 32'h3);
    check("R4 blkRstOut reasserted", {31'b0, blkRstOut}, 32'h1);

    // R8 unused address
    regWrite(2'd3, 32'hFFFF_FFFF); settle();
    regRead(2'd3, v); check("R8 addr3 reads 0", v, 32'h0);
    regRead(2'd0, v); check("R8 ctl untouched", v, 32'h8000_0000);
    regRead(2'd1, v); check("R8 vote untouched", v, 32'h0);
    regRead(2'd2, v); check("R8 blkrst untouched", v, 32'h1);
    regWrite(2'd2, 32'h0);

    // R5 every gated pulse was a full source high phase
    check("R5 no short pulses", shortPulses, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule